// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer whose write port and read port run on two unrelated clocks. Words enter on the write clock when the active-low write enable is asserted and the buffer has room. They leave through a registered output on the read clock. Each side has a single status output that tells its user when to stop: `wrHalt` on the write side and `rdHalt` on the read side. Pointers cross between the domains as Gray code through two-stage synchronisers, so each status output follows activity on the far side after a fixed number of local clock edges.

The read behaviour is chosen while master reset is held. In standard mode, every word has to be requested with read enable, including the first word written into an empty buffer. `rdHalt` then acts as an empty flag and `wrHalt` as a full flag. In fall-through mode the oldest word moves to the output register on its own, and `rdHalt` low means the word on `rdData` is valid. Only the words after it need read enable. In this mode `wrHalt` acts as an input-ready flag, and the output register counts as one extra storage place.

A producer stops writing while `wrHalt` is high, and a consumer reads only while `rdHalt` is low. An enable asserted against a raised halt is ignored without harm.

Top module: `xclk_fifo`

## Requirements
- R1: While `mrstN` is low, `rdHalt` is 1, `wrHalt` is 0 and `rdData` is 0. Reset clears both pointers, so the buffer starts empty and not full.
- R2: `fallThrough` is sampled only while `mrstN` is low (1 selects fall-through mode, 0 selects standard mode). Changing it after reset is released has no effect on behaviour.
- R3: In standard mode, a read-clock edge with `rdEnN` low and `rdHalt` low loads the oldest word into `rdData`. After the edge that reads the last stored word, `rdHalt` is 1.
- R4: In fall-through mode, the first word written into an empty buffer appears on `rdData`, with `rdHalt` low, at the third read-clock rising edge after the write edge, without any read request. Each later word needs an edge with `rdEnN` low. On the edge that reads the last word, `rdHalt` goes to 1.
- R5: In standard mode, after a write into an empty buffer, `rdHalt` falls at the second read-clock rising edge after the write edge.
- R6: After a read frees a location in a full buffer, `wrHalt` falls at the second write-clock rising edge after that read edge, in both modes.
- R7: `rdEnN` low is ignored while `rdHalt` is 1: no data moves and the read pointer does not advance. `wrEnN` low is ignored while `wrHalt` is 1: nothing is stored.
- R8: While `rdEnN` is high and a word is present on the output, `rdData` holds its value.
- R9: With no reads, the buffer accepts exactly `2**ADDR_W` words in standard mode and `2**ADDR_W + 1` words in fall-through mode before `wrHalt` stays high.
- R10: Under concurrent random traffic in either mode, the words leave in the order they were accepted, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock, unrelated to `wrClk` |
| mrstN | input | 1 | Master reset, active low, asynchronous assertion |
| fallThrough | input | 1 | Mode select sampled during reset: 1 fall-through, 0 standard |
| wrEnN | input | 1 | Write enable, active low |
| wrData | input | DATA_W | Word to store |
| wrHalt | output | 1 | 1 = full (standard) or not input-ready (fall-through) |
| rdEnN | input | 1 | Read enable, active low |
| rdData | output | DATA_W | Registered output word |
| rdHalt | output | 1 | 1 = empty (standard) or output not ready (fall-through) |

## Verification
The assertions take it for granted that `mrstN` is held low across at least one read-clock rising edge, so the mode is captured. They also assume that enables and data change away from the clock edges that sample them, and that the two clocks never rise at the same instant. The bench meets these assumptions in three ways. It drives every input on a falling edge of its own clock. It releases reset on a falling write-clock edge. It gives the read clock a period and phase whose rising edges always stay a fraction of a nanosecond clear of write-clock edges, which also makes the counted cross-clock latencies deterministic.

// File: rtl/xclk_fifo_pkg.sv
`timescale 1ns/1ps
package xclk_fifo_pkg;

  // Strobes issued by the control half to the datapath half.
  typedef struct packed {
    logic wrStore;  // write-clock domain: store wrData at the write address
    logic rdLoad;   // read-clock domain: move the addressed word into the output register
  } fifo_strobe_t;

endpackage

// File: rtl/xclk_fifo_sync.sv
`timescale 1ns/1ps
module xclk_fifo_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/xclk_fifo_ctrl.sv
`timescale 1ns/1ps
module xclk_fifo_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              fallThrough,
  input  logic              wrEnN,
  input  logic              rdEnN,
  output fifo_strobe_t      strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrHalt,
  output logic              rdHalt
);

  localparam int PW = ADDR_W + 1;   // pointer width with wrap bit

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] binToGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wrPtrBin, wrPtrGray, wrPtrNext;
  logic [PW-1:0] rdSyncGray, rdSyncBin;
  logic          wrFull, wrStore;

  xclk_fifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk (wrClk),
    .rstN(mrstN),
    .din (rdPtrGray),
    .dout(rdSyncGray)
  );

  assign rdSyncBin = grayToBin(rdSyncGray);
  assign wrFull    = (wrPtrBin[PW-1] != rdSyncBin[PW-1]) &&
                     (wrPtrBin[PW-2:0] == rdSyncBin[PW-2:0]);
  assign wrStore   = !wrEnN && !wrFull;
  assign wrPtrNext = wrPtrBin + PW'(1);

  always_ff @(posedge wrClk or negedge mrstN) begin
    if (!mrstN) begin
      wrPtrBin  <= '0;
      wrPtrGray <= '0;
    end else if (wrStore) begin
      wrPtrBin  <= wrPtrNext;
      wrPtrGray <= binToGray(wrPtrNext);
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rdPtrBin, rdPtrGray, rdPtrNext;
  logic [PW-1:0] wrSyncGray;
  logic          ramEmpty, loadNow, outValid, modeFwft;

  xclk_fifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk (rdClk),
    .rstN(mrstN),
    .din (wrPtrGray),
    .dout(wrSyncGray)
  );

  // Mode is captured on read-clock edges only while reset is held.
  always_ff @(posedge rdClk) begin
    if (!mrstN) modeFwft <= fallThrough;
  end

  assign ramEmpty  = (rdPtrGray == wrSyncGray);
  assign rdPtrNext = rdPtrBin + PW'(1);

  always_comb begin
    if (modeFwft) loadNow = !ramEmpty && (!outValid || !rdEnN);
    else          loadNow = !ramEmpty && !rdEnN;
  end

  always_ff @(posedge rdClk or negedge mrstN) begin
    if (!mrstN) begin
      rdPtrBin  <= '0;
      rdPtrGray <= '0;
      outValid  <= 1'b0;
    end else begin
      if (loadNow) begin
        rdPtrBin  <= rdPtrNext;
        rdPtrGray <= binToGray(rdPtrNext);
      end
      if (modeFwft) begin
        if (loadNow)     outValid <= 1'b1;
        else if (!rdEnN) outValid <= 1'b0;   // true read of the last word
      end
    end
  end

  // ---------------- outputs ----------------
  assign strobe.wrStore = wrStore;
  assign strobe.rdLoad  = loadNow;
  assign wrAddr         = wrPtrBin[PW-2:0];
  assign rdAddr         = rdPtrBin[PW-2:0];
  assign wrHalt         = wrFull;
  assign rdHalt         = modeFwft ? !outValid : ramEmpty;

endmodule

// File: rtl/xclk_fifo_dpath.sv
`timescale 1ns/1ps
module xclk_fifo_dpath
  import xclk_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  fifo_strobe_t      strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (strobe.wrStore) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge mrstN) begin
    if (!mrstN)             outReg <= '0;
    else if (strobe.rdLoad) outReg <= store[rdAddr];
  end

  assign rdData = outReg;

endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              fallThrough,
  input  logic              wrEnN,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrHalt,
  input  logic              rdEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdHalt
);

  fifo_strobe_t      strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  xclk_fifo_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .mrstN      (mrstN),
    .fallThrough(fallThrough),
    .wrEnN      (wrEnN),
    .rdEnN      (rdEnN),
    .strobe     (strobe),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .wrHalt     (wrHalt),
    .rdHalt     (rdHalt)
  );

  xclk_fifo_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .mrstN (mrstN),
    .strobe(strobe),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .wrData(wrData),
    .rdData(rdData)
  );

endmodule

// File: rtl/xclk_fifo_checker.sv
`timescale 1ns/1ps
module xclk_fifo_checker #(
  parameter int DATA_W = 16
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              mrstN,
  input logic              fallThrough,
  input logic              wrEnN,
  input logic              wrHalt,
  input logic              rdEnN,
  input logic              rdHalt,
  input logic [DATA_W-1:0] rdData
);

  // Independent copy of the captured mode, taken from the pins.
  logic ckMode;
  always_ff @(posedge rdClk) begin
    if (!mrstN) ckMode <= fallThrough;
  end

  // R1: reset state seen on every read edge while reset is held
  always @(posedge rdClk) begin
    if (!mrstN) begin
      a_r1_reset_state: assert (rdHalt && !wrHalt && rdData == '0)
        else $error("R1 reset state wrong");
    end
  end

  // R8: no request and a word present -> the output holds
  a_r8_hold_output: assert property (@(posedge rdClk) disable iff (!mrstN)
    (rdEnN && !rdHalt) |=> $stable(rdData));

  // R3 / R4: a present word cannot vanish without a read
  a_r3_ready_persists: assert property (@(posedge rdClk) disable iff (!mrstN)
    (rdEnN && !rdHalt) |=> !rdHalt);

  // R7: standard mode, a read against an empty buffer moves no data
  a_r7_no_underflow: assert property (@(posedge rdClk) disable iff (!mrstN)
    (!ckMode && rdHalt && !rdEnN) |=> $stable(rdData));

  // R9: the write side can only become blocked through a write
  a_r9_full_needs_write: assert property (@(posedge wrClk) disable iff (!mrstN)
    (!wrHalt && wrEnN) |=> !wrHalt);

endmodule

bind xclk_fifo xclk_fifo_checker #(.DATA_W(DATA_W)) u_check (
  .wrClk      (wrClk),
  .rdClk      (rdClk),
  .mrstN      (mrstN),
  .fallThrough(fallThrough),
  .wrEnN      (wrEnN),
  .wrHalt     (wrHalt),
  .rdEnN      (rdEnN),
  .rdHalt     (rdHalt),
  .rdData     (rdData)
);

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/100ps
module xclk_fifo_bench;

  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          wrClk, rdClk, mrstN, fallThrough, wrEnN, rdEnN;
  logic [DW-1:0] wrData, rdData;
  logic          wrHalt, rdHalt;

  int checks = 0;
  int errors = 0;
  bit summaryDone = 0;
  logic [DW-1:0] model [$];

  xclk_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_xclk_fifo (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .fallThrough(fallThrough),
    .wrEnN(wrEnN), .wrData(wrData), .wrHalt(wrHalt),
    .rdEnN(rdEnN), .rdData(rdData), .rdHalt(rdHalt)
  );

  // 125 MHz write clock; read clock rises at 6.8 + 11k ns, never on a write edge
  initial begin wrClk = 0; forever #4 wrClk = ~wrClk; end
  initial begin rdClk = 0; #1.3; forever #5.5 rdClk = ~rdClk; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  task automatic doReset(input bit ft);
    @(negedge wrClk);
    mrstN = 0; fallThrough = ft; wrEnN = 1; rdEnN = 1;
    repeat (3) @(posedge rdClk);
    @(negedge wrClk);
    mrstN = 1;
    fallThrough = !ft;            // R2: must be ignored from now on
    model.delete();
  endtask

  task automatic writeWord(input logic [DW-1:0] d, output bit acc);
    @(negedge wrClk);
    wrData = d; wrEnN = 0;
    acc = !wrHalt;
    if (acc) model.push_back(d);
    @(posedge wrClk);
    #0.1 wrEnN = 1;
  endtask

  task automatic readWord(output logic [DW-1:0] q);
    @(negedge rdClk);
    rdEnN = 0;
    @(posedge rdClk);
    #0.1 rdEnN = 1;
    q = rdData;
  endtask

  task automatic idleRd(input int n);
    repeat (n) @(posedge rdClk);
    #0.1;
  endtask

  // Directed sequence for one mode
  task automatic directed(input bit ft);
    bit acc;
    int n;
    logic [DW-1:0] q;
    logic [DW-1:0] d0 = 16'hA5A1, d1 = 16'h3C12, d2 = 16'h7E03;

    doReset(ft);
    @(negedge rdClk);
    chk("R1 rdHalt after reset", rdHalt, 1);
    chk("R1 wrHalt after reset", wrHalt, 0);
    chk("R1 rdData after reset", rdData, 0);

    // first-word latency, mode latched despite the changed select pin
    writeWord(d0, acc);
    n = 0;
    do begin @(posedge rdClk); #0.1; n++; end while (rdHalt && n < 8);
    if (ft) begin
      chk("R4 R2 fall-through first-word edge count", n, 3);
      chk("R4 first word shown without request", rdData, d0);
    end else begin
      chk("R5 R2 empty flag release edge count", n, 2);
      chk("R3 no data before request", rdData, 0);
    end

    readWord(q);
    if (!ft) chk("R3 requested word", q, d0);
    chk("R3 R4 halt after last word read", rdHalt, 1);
    void'(model.pop_front());

    // read against empty: ignored
    readWord(q);
    chk("R7 read while empty keeps data", q, d0);
    chk("R7 read while empty keeps halt", rdHalt, 1);

    writeWord(d1, acc);
    writeWord(d2, acc);
    idleRd(8);
    chk(ft ? "R4 next word auto-shown" : "R8 output held without request",
        rdData, ft ? d1 : d0);
    idleRd(4);
    chk("R8 output held", rdData, ft ? d1 : d0);

    readWord(q);
    if (ft) chk("R4 later word needs request", q, d2);
    else    chk("R7 pointer not advanced by empty read", q, d1);
    idleRd(4);
    chk("R8 hold after read", rdData, ft ? d2 : d1);
    readWord(q);
    if (!ft) chk("R3 second word", q, d2);
    chk("R3 R4 empty after draining", rdHalt, 1);
    model.delete();

    // capacity with no reads; extra attempts while blocked are ignored
    doReset(ft);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      writeWord(DW'(16'h1000 + i), acc);
      if (acc) n++;
    end
    chk("R9 words accepted before full", n, DEPTH + (ft ? 1 : 0));
    chk("R9 wrHalt high when full", wrHalt, 1);

    // full release latency
    if (ft) begin
      chk("R7 head intact after blocked writes", rdData, model[0]);
      void'(model.pop_front());
      readWord(q);
    end else begin
      readWord(q);
      chk("R7 head intact after blocked writes", q, model.pop_front());
    end
    n = 0;
    do begin @(posedge wrClk); #0.1; n++; end while (wrHalt && n < 8);
    chk("R6 full release edge count", n, 2);

    // drain the rest in order
    while (model.size() > 0) begin
      n = 0;
      while (rdHalt && n < 20) begin @(posedge rdClk); #0.1; n++; end
      if (ft) begin
        chk("R10 drained word", rdData, model.pop_front());
        readWord(q);
      end else begin
        readWord(q);
        chk("R10 drained word", q, model.pop_front());
      end
    end
    idleRd(4);
    chk("R3 R4 empty after full drain", rdHalt, 1);
  endtask

  task automatic randomPhase(input bit ft, input int wrPct, input int rdPct, input int cycles);
    bit writerDone = 0;
    bit pending = 0;
    logic [DW-1:0] expq = '0;
    fork
      begin
        for (int i = 0; i < cycles; i++) begin
          @(negedge wrClk);
          wrEnN  = !(($urandom % 100) < wrPct);
          wrData = DW'($urandom);
          if (!wrEnN && !wrHalt) model.push_back(wrData);
        end
        @(negedge wrClk);
        wrEnN = 1;
        writerDone = 1;
      end
      begin
        while (!(writerDone && model.size() == 0 && !pending)) begin
          @(negedge rdClk);
          if (pending) begin
            chk("R10 random order (standard)", rdData, expq);
            pending = 0;
          end
          if (ft && !rdHalt) chk("R10 random order (fall-through)", rdData, model[0]);
          rdEnN = !(($urandom % 100) < rdPct);
          if (!rdEnN && !rdHalt) begin
            if (ft) void'(model.pop_front());
            else begin expq = model.pop_front(); pending = 1; end
          end
        end
        @(posedge rdClk);
        #0.1 rdEnN = 1;
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge wrClk);
    errors++;
    $display("FAIL R10 watchdog expired: actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mrstN = 1; fallThrough = 0; wrEnN = 1; rdEnN = 1; wrData = '0;
    #2 mrstN = 0;
    for (int m = 0; m < 2; m++) begin
      directed(m == 1);
      doReset(m == 1);
      randomPhase(m == 1, 70, 30, 400);
      randomPhase(m == 1, 30, 80, 400);
      randomPhase(m == 1, 50, 50, 400);
      @(negedge rdClk);
      chk("R10 empty after random traffic", rdHalt, 1);
    end
    summary();
    $finish;
  end

endmodule